// File: doc/BRIEF.md
# Interrupt Claim/Complete Register File

This block is the software-visible state of a platform interrupt controller. It keeps one priority per interrupt source, a pending bit and a claimed bit per source, one enable mask and one threshold per target context, and a claim/complete register in each context window. An external arbiter reads the priorities, enables, thresholds and the pending-but-not-claimed state from the block's outputs. It returns the winning source ID of each context, with 0 meaning none, and it drives the request lines to the targets itself.

Software reaches the block through a simple 32-bit, little-endian, single-cycle bus. A read returns its data in the following cycle. Reading a context's claim register hands the arbiter's current winner to software and moves that source from pending to claimed in the same access. Writing a source ID back to the same register completes the interrupt and releases the claimed bit. All region bases and strides are parameters. The strides must be powers of two.

Level inputs from the sources drive the pending bits. A pending bit follows a source only when that source's level changes. A source whose line stays high after it has been claimed is therefore not re-posted until its line drops and rises again.

Top module: `irq_claim_regs`

## Requirements
- R1: Every bus access is a 32-bit word access. A read presents its data on `busRdata` in the cycle after the access. In any cycle that follows a write or an idle cycle, `busRdata` is 0.
- R2: The priority of source s (1 to NUM_SRC-1) is the word at `PRIO_BASE + 4*(s-1)`. It reads back with the stored value in bits [PRIO_W-1:0]. Source 0 has no priority word.
- R3: When MAX_PRIO+1 is a power of two, a priority write stores the written value modulo MAX_PRIO+1.
- R4: When MAX_PRIO+1 is not a power of two, a priority or threshold write with a value above MAX_PRIO leaves the register unchanged. A value at or below MAX_PRIO is stored.
- R5: The pending word at `PEND_BASE` reads bit s as the pending bit of source s. Writes to it change nothing.
- R6: The enable mask of context c is at `EN_BASE + c*EN_STRIDE`. Bit s enables source s. Further words inside a context's enable stride read 0 and ignore writes.
- R7: The threshold of context c is at offset 0 of its window `CTX_BASE + c*CTX_STRIDE`. It obeys the same filtering as a priority.
- R8: A read at offset 4 of a context window returns that context's `winId`. If the value is nonzero, the access clears that source's pending bit and sets its claimed bit at the same clock edge.
- R9: A write at offset 4 of any context window clears the claimed bit of the written ID when the ID is below NUM_SRC. A larger value has no effect.
- R10: A pending bit takes the level of its source input when that level differs from the level of the previous cycle. Otherwise the bit keeps its value. Source 0 is never pending or claimed.
- R11: When a claim and a level change hit the same source in one cycle, the claim wins and the pending bit ends at 0.
- R12: An active-low reset clears all priorities, thresholds, enables, pending bits and claimed bits.
- R13: A read from any address outside the mapped words returns 0. Examples are a gap between regions, a context window offset other than 0 and 4, and a context index of NUM_CTX or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read |
| srcLevel | input | NUM_SRC-1 | Level inputs of sources 1 to NUM_SRC-1 |
| winId | input | NUM_CTX*ID_W | Arbiter winner per context, context c in bits [c*ID_W +: ID_W] |
| srcPrio | output | NUM_SRC*PRIO_W | Priority of source s in bits [s*PRIO_W +: PRIO_W] |
| ctxThresh | output | NUM_CTX*PRIO_W | Threshold per context |
| ctxEnable | output | NUM_CTX*NUM_SRC | Enable mask per context |
| pendingVec | output | NUM_SRC | Pending bit per source |
| claimedVec | output | NUM_SRC | Claimed bit per source |

## Verification
A claim read and a level change on the source being claimed can meet at one clock edge. Both then act on the same pending bit. The bench provokes this by raising a source's line in the same cycle in which it reads the claim register of a context whose winner is that source. It then judges that the pending bit is 0 and the claimed bit is 1. The random phase produces the same collision many more times by toggling lines while it issues claim reads. Every cycle is compared against a behavioural model in which the claim is applied after the level update.

// File: rtl/irqrf_pkg.sv
package irqrf_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_PEND,
    RD_EN,
    RD_THRESH,
    RD_CLAIM
  } rdSel_e;

  // Strobes from the decoder to the storage
  typedef struct packed {
    logic        prioWe;
    logic        threshWe;
    logic        enWe;
    logic        claimRd;
    logic        completeWe;
    logic        rdEn;
    rdSel_e      rdSel;
    logic [15:0] unit;   // source or context index
    logic [15:0] word;   // word within a bit array
    logic [31:0] value;  // filtered write value
  } strobe_t;

endpackage

// File: rtl/irqrf_decode.sv
module irqrf_decode
  import irqrf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_SRC    = 16,
  parameter int NUM_CTX    = 2,
  parameter int MAX_PRIO   = 7,
  parameter int PRIO_BASE  = 'h4,
  parameter int PEND_BASE  = 'h1000,
  parameter int EN_BASE    = 'h2000,
  parameter int EN_STRIDE  = 'h80,
  parameter int CTX_BASE   = 'h8000,
  parameter int CTX_STRIDE = 'h1000
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output strobe_t           stb
);

  localparam int SRC_WORDS = (NUM_SRC + 31) / 32;
  localparam int PRIO_SPAN = (NUM_SRC - 1) * 4;
  localparam int PEND_SPAN = SRC_WORDS * 4;
  localparam int EN_SPAN   = NUM_CTX * EN_STRIDE;
  localparam int CTX_SPAN  = NUM_CTX * CTX_STRIDE;
  localparam int EN_SH     = $clog2(EN_STRIDE);
  localparam int CTX_SH    = $clog2(CTX_STRIDE);
  localparam bit LEVELS_POW2 = ((MAX_PRIO + 1) & MAX_PRIO) == 0;

  logic [31:0] addr, oPrio, oPend, oEn, oCtx, enWord, ctxSub;
  logic        hitPrio, hitPend, hitEn, hitCtx;
  logic        levelOk;
  logic [31:0] levelVal;
  logic        rdReq, wrReq;

  // Level filtering: wrap when the level count is a power of two, else reject
  generate
    if (LEVELS_POW2) begin : g_wrap
      assign levelVal = busWdata & 32'(MAX_PRIO);
      assign levelOk  = 1'b1;
    end else begin : g_reject
      assign levelVal = busWdata;
      assign levelOk  = busWdata <= 32'(MAX_PRIO);
    end
  endgenerate

  always_comb begin
    addr    = 32'(busAddr);
    oPrio   = addr - 32'(PRIO_BASE);
    oPend   = addr - 32'(PEND_BASE);
    oEn     = addr - 32'(EN_BASE);
    oCtx    = addr - 32'(CTX_BASE);
    hitPrio = (addr >= 32'(PRIO_BASE)) && (oPrio < 32'(PRIO_SPAN));
    hitPend = (addr >= 32'(PEND_BASE)) && (oPend < 32'(PEND_SPAN));
    hitEn   = (addr >= 32'(EN_BASE))   && (oEn   < 32'(EN_SPAN));
    hitCtx  = (addr >= 32'(CTX_BASE))  && (oCtx  < 32'(CTX_SPAN));
    enWord  = (oEn & 32'(EN_STRIDE - 1)) >> 2;
    ctxSub  = (oCtx & 32'(CTX_STRIDE - 1)) >> 2;
    rdReq   = busSel && !busWr;
    wrReq   = busSel && busWr;

    stb       = '0;
    stb.rdEn  = rdReq;
    stb.value = busWdata;

    if (hitPrio) begin
      stb.unit   = 16'((oPrio >> 2) + 32'd1);
      stb.rdSel  = RD_PRIO;
      stb.prioWe = wrReq && levelOk;
      stb.value  = levelVal;
    end else if (hitPend) begin
      stb.word  = 16'(oPend >> 2);
      stb.rdSel = RD_PEND;
    end else if (hitEn) begin
      if (enWord < 32'(SRC_WORDS)) begin
        stb.unit  = 16'(oEn >> EN_SH);
        stb.word  = 16'(enWord);
        stb.rdSel = RD_EN;
        stb.enWe  = wrReq;
      end
    end else if (hitCtx) begin
      stb.unit = 16'(oCtx >> CTX_SH);
      if (ctxSub == 32'd0) begin
        stb.rdSel    = RD_THRESH;
        stb.threshWe = wrReq && levelOk;
        stb.value    = levelVal;
      end else if (ctxSub == 32'd1) begin
        stb.rdSel      = RD_CLAIM;
        stb.claimRd    = rdReq;
        stb.completeWe = wrReq && (busWdata < 32'(NUM_SRC));
      end
    end
  end

endmodule

// File: rtl/irqrf_store.sv
module irqrf_store
  import irqrf_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [NUM_SRC-1:1]          srcLevel,
  input  logic [NUM_CTX*ID_W-1:0]     winId,
  output logic [31:0]                 busRdata,
  output logic [NUM_SRC*PRIO_W-1:0]   srcPrio,
  output logic [NUM_CTX*PRIO_W-1:0]   ctxThresh,
  output logic [NUM_CTX*NUM_SRC-1:0]  ctxEnable,
  output logic [NUM_SRC-1:0]          pendingVec,
  output logic [NUM_SRC-1:0]          claimedVec
);

  logic [ID_W-1:0] curId;
  logic            claimHit;
  logic [31:0]     rdNext;

  // Winner of the addressed context
  always_comb begin
    curId = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (stb.unit == 16'(c)) curId = winId[c*ID_W +: ID_W];
    end
  end

  assign claimHit = stb.claimRd && (curId != '0);

  // Per-source state
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == 0) begin : g_null
        assign pendingVec[0]        = 1'b0;
        assign claimedVec[0]        = 1'b0;
        assign srcPrio[PRIO_W-1:0]  = '0;
      end else begin : g_live
        logic              lvlQ, pendQ, clmQ;
        logic [PRIO_W-1:0] prioQ;
        logic              claimMe;

        assign claimMe = claimHit && (curId == ID_W'(i));

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            lvlQ  <= 1'b0;
            pendQ <= 1'b0;
            clmQ  <= 1'b0;
            prioQ <= '0;
          end else begin
            lvlQ <= srcLevel[i];
            // claim takes precedence over a level change
            if (claimMe)                    pendQ <= 1'b0;
            else if (srcLevel[i] != lvlQ)   pendQ <= srcLevel[i];
            if (claimMe)                    clmQ <= 1'b1;
            else if (stb.completeWe && stb.value == 32'(i)) clmQ <= 1'b0;
            if (stb.prioWe && stb.unit == 16'(i)) prioQ <= stb.value[PRIO_W-1:0];
          end
        end

        assign pendingVec[i]                 = pendQ;
        assign claimedVec[i]                 = clmQ;
        assign srcPrio[i*PRIO_W +: PRIO_W]   = prioQ;
      end
    end
  endgenerate

  // Per-context state
  generate
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic [PRIO_W-1:0]  thrQ;
      logic [NUM_SRC-1:0] enQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          thrQ <= '0;
          enQ  <= '0;
        end else begin
          if (stb.threshWe && stb.unit == 16'(c)) thrQ <= stb.value[PRIO_W-1:0];
          if (stb.enWe && stb.unit == 16'(c)) begin
            for (int j = 0; j < NUM_SRC; j++) begin
              if (stb.word == 16'(j / 32)) enQ[j] <= stb.value[j % 32];
            end
          end
        end
      end

      assign ctxThresh[c*PRIO_W +: PRIO_W]   = thrQ;
      assign ctxEnable[c*NUM_SRC +: NUM_SRC] = enQ;
    end
  endgenerate

  // Read multiplexer
  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RD_PRIO: begin
        for (int s = 1; s < NUM_SRC; s++) begin
          if (stb.unit == 16'(s)) rdNext = 32'(srcPrio[s*PRIO_W +: PRIO_W]);
        end
      end
      RD_PEND: begin
        for (int j = 0; j < NUM_SRC; j++) begin
          if (stb.word == 16'(j / 32)) rdNext[j % 32] = pendingVec[j];
        end
      end
      RD_EN: begin
        for (int c = 0; c < NUM_CTX; c++) begin
          for (int j = 0; j < NUM_SRC; j++) begin
            if (stb.unit == 16'(c) && stb.word == 16'(j / 32))
              rdNext[j % 32] = ctxEnable[c*NUM_SRC + j];
          end
        end
      end
      RD_THRESH: begin
        for (int c = 0; c < NUM_CTX; c++) begin
          if (stb.unit == 16'(c)) rdNext = 32'(ctxThresh[c*PRIO_W +: PRIO_W]);
        end
      end
      RD_CLAIM: rdNext = 32'(curId);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdNext;
    else               busRdata <= '0;
  end

endmodule

// File: rtl/irq_claim_regs.sv
module irq_claim_regs
  import irqrf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_SRC    = 16,
  parameter int NUM_CTX    = 2,
  parameter int MAX_PRIO   = 7,
  parameter int PRIO_BASE  = 'h4,
  parameter int PEND_BASE  = 'h1000,
  parameter int EN_BASE    = 'h2000,
  parameter int EN_STRIDE  = 'h80,
  parameter int CTX_BASE   = 'h8000,
  parameter int CTX_STRIDE = 'h1000,
  localparam int ID_W      = $clog2(NUM_SRC),
  localparam int PRIO_W    = $clog2(MAX_PRIO + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSel,
  input  logic                        busWr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic [NUM_SRC-1:1]          srcLevel,
  input  logic [NUM_CTX*ID_W-1:0]     winId,
  output logic [NUM_SRC*PRIO_W-1:0]   srcPrio,
  output logic [NUM_CTX*PRIO_W-1:0]   ctxThresh,
  output logic [NUM_CTX*NUM_SRC-1:0]  ctxEnable,
  output logic [NUM_SRC-1:0]          pendingVec,
  output logic [NUM_SRC-1:0]          claimedVec
);

  strobe_t stb;

  irqrf_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .MAX_PRIO(MAX_PRIO),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_decode (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .stb(stb)
  );

  irqrf_store #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .srcLevel(srcLevel), .winId(winId),
    .busRdata(busRdata), .srcPrio(srcPrio), .ctxThresh(ctxThresh),
    .ctxEnable(ctxEnable), .pendingVec(pendingVec), .claimedVec(claimedVec)
  );

endmodule

// File: rtl/irqrf_checker.sv
module irqrf_checker #(
  parameter int ADDR_W     = 16,
  parameter int NUM_SRC    = 16,
  parameter int NUM_CTX    = 2,
  parameter int CTX_BASE   = 'h8000,
  parameter int CTX_STRIDE = 'h1000,
  parameter int ID_W       = 4,
  parameter int PRIO_W     = 3
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busSel,
  input logic                       busWr,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [31:0]                busWdata,
  input logic [31:0]                busRdata,
  input logic [NUM_SRC-1:1]         srcLevel,
  input logic [NUM_CTX*ID_W-1:0]    winId,
  input logic [NUM_SRC*PRIO_W-1:0]  srcPrio,
  input logic [NUM_SRC-1:0]         pendingVec,
  input logic [NUM_SRC-1:0]         claimedVec
);

  logic [31:0]        off;
  logic               inCtx, atClaim, claimRd, completeWr;
  logic [ID_W-1:0]    ctxWin;
  logic [NUM_SRC-1:1] lvlSeen;
  logic               wasInReset;

  always_comb begin
    off     = 32'(busAddr) - 32'(CTX_BASE);
    inCtx   = (32'(busAddr) >= 32'(CTX_BASE)) && (off < 32'(NUM_CTX * CTX_STRIDE));
    atClaim = inCtx && (((off & 32'(CTX_STRIDE - 1)) >> 2) == 32'd1);
    ctxWin  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if ((off / 32'(CTX_STRIDE)) == 32'(c)) ctxWin = winId[c*ID_W +: ID_W];
    end
  end

  assign claimRd    = busSel && !busWr && atClaim;
  assign completeWr = busSel && busWr && atClaim && (busWdata < 32'(NUM_SRC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlSeen    <= '0;
      wasInReset <= 1'b1;
    end else begin
      lvlSeen    <= srcLevel;
      wasInReset <= 1'b0;
    end
  end

  AST_CLAIM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    claimRd |=> busRdata == 32'($past(ctxWin)));  // R8

  AST_CLAIM_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && ctxWin != '0) |=>
      (!pendingVec[$past(ctxWin)] && claimedVec[$past(ctxWin)]));  // R8

  AST_COMPLETE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    completeWr |=> !claimedVec[$past(busWdata[ID_W-1:0])]);  // R9

  AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!claimRd && srcLevel == lvlSeen) |=> $stable(pendingVec));  // R10

  AST_SRC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pendingVec[0] && !claimedVec[0]);  // R10

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wasInReset |-> (pendingVec == '0 && claimedVec == '0 && srcPrio == '0));  // R12

endmodule

bind irq_claim_regs irqrf_checker #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
  .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE), .ID_W(ID_W), .PRIO_W(PRIO_W)
) u_irqrf_checker (.*);

// File: tb/test_irq_claim_regs.sv
module test_irq_claim_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NC = 2;
  localparam int MP = 7;
  localparam int IDW = 4;
  localparam int PW = 3;
  localparam int PEND = 'h1000;
  localparam int ENB = 'h2000;
  localparam int ES = 'h80;
  localparam int CB = 'h8000;
  localparam int CS = 'h1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [NS-1:1] srcLevel = '0;
  logic [NC*IDW-1:0] winId = '0;

  logic [31:0] busRdata, oddRdata;
  logic [NS*PW-1:0] srcPrio, oddPrio;
  logic [NC*PW-1:0] ctxThresh, oddThresh;
  logic [NC*NS-1:0] ctxEnable, oddEnable;
  logic [NS-1:0] pendingVec, claimedVec, oddPend, oddClaimed;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_claim_regs i_irq_claim_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcLevel(srcLevel), .winId(winId),
    .srcPrio(srcPrio), .ctxThresh(ctxThresh), .ctxEnable(ctxEnable),
    .pendingVec(pendingVec), .claimedVec(claimedVec));

  // Variant with a level count that is not a power of two
  irq_claim_regs #(.MAX_PRIO(5)) i_irq_claim_regs_odd (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(oddRdata), .srcLevel(srcLevel), .winId(winId),
    .srcPrio(oddPrio), .ctxThresh(oddThresh), .ctxEnable(oddEnable),
    .pendingVec(oddPend), .claimedVec(oddClaimed));

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R12";

  // Behavioural reference model
  int mPrio[NS];
  int mThr[NC];
  bit [NS-1:0] mEn[NC];
  bit [NS-1:0] mPend, mClm, mPrev;
  bit [31:0] mRd;

  function automatic bit legalLevel(input bit [31:0] d, output int v);
    if (((MP + 1) & MP) == 0) begin
      v = int'(d % (MP + 1));
      return 1;
    end
    v = int'(d);
    return d <= MP;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mPrio[i]) mPrio[i] = 0;
      foreach (mThr[i]) mThr[i] = 0;
      foreach (mEn[i]) mEn[i] = '0;
      mPend = '0; mClm = '0; mPrev = '0; mRd = '0;
    end else begin
      int a, c, w, v, claimIdx;
      bit [NS-1:0] lvl;
      bit [31:0] rd;
      rd = '0; claimIdx = 0;
      a = int'(busAddr);
      lvl = {srcLevel, 1'b0};
      if (busSel) begin
        if (a >= 4 && a < 4 + (NS - 1) * 4) begin
          c = (a - 4) / 4 + 1;
          if (busWr) begin if (legalLevel(busWdata, v)) mPrio[c] = v; end
          else rd = mPrio[c];
        end else if (a >= PEND && a < PEND + 4) begin
          if (!busWr) rd = 32'(mPend);
        end else if (a >= ENB && a < ENB + NC * ES) begin
          c = (a - ENB) / ES; w = ((a - ENB) % ES) / 4;
          if (w == 0) begin
            if (busWr) mEn[c] = busWdata[NS-1:0];
            else rd = 32'(mEn[c]);
          end
        end else if (a >= CB && a < CB + NC * CS) begin
          c = (a - CB) / CS; w = ((a - CB) % CS) / 4;
          if (w == 0) begin
            if (busWr) begin if (legalLevel(busWdata, v)) mThr[c] = v; end
            else rd = mThr[c];
          end else if (w == 1) begin
            if (!busWr) begin
              rd = 32'(winId[c*IDW +: IDW]);
              claimIdx = int'(winId[c*IDW +: IDW]);
            end else if (busWdata < NS) mClm[busWdata] = 1'b0;
          end
        end
      end
      for (int i = 1; i < NS; i++) begin
        if (lvl[i] != mPrev[i]) mPend[i] = lvl[i];
      end
      if (claimIdx != 0) begin
        mPend[claimIdx] = 1'b0;
        mClm[claimIdx] = 1'b1;
      end
      mPrev = lvl;
      mRd = rd;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    logic [NS*PW-1:0] eP;
    logic [NC*PW-1:0] eT;
    logic [NC*NS-1:0] eE;
    if (!done) begin
      for (int s = 0; s < NS; s++) eP[s*PW +: PW] = PW'(mPrio[s]);
      for (int c = 0; c < NC; c++) begin
        eT[c*PW +: PW] = PW'(mThr[c]);
        eE[c*NS +: NS] = mEn[c];
      end
      check(busRdata === mRd, curReq, "rdata", 64'(busRdata), 64'(mRd));
      check(srcPrio === eP, "R2", "srcPrio", 64'(srcPrio), 64'(eP));
      check(ctxThresh === eT, "R7", "ctxThresh", 64'(ctxThresh), 64'(eT));
      check(ctxEnable === eE, "R6", "ctxEnable", 64'(ctxEnable), 64'(eE));
      check(pendingVec === mPend, "R10", "pendingVec", 64'(pendingVec), 64'(mPend));
      check(claimedVec === mClm, "R8", "claimedVec", 64'(claimedVec), 64'(mClm));
    end
  end

  task automatic busOp(input bit wr, input int addr, input logic [31:0] data);
    busSel = 1'b1; busWr = wr; busAddr = 16'(addr); busWdata = data;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    curReq = "R3";
    busOp(1, 'hC, 13);          // source 3 -> 5
    busOp(0, 'hC, 0);
    curReq = "R2";
    busOp(1, 'h4, 6);           // source 1 = 6; odd variant rejects
    @(negedge clk);
    check(oddPrio[2*PW +: PW] == '0 && oddPrio[PW +: PW] == '0, "R4", "odd prio src1",
          64'(oddPrio[PW +: PW]), 0);
    idle(1);
    busOp(1, 'h8, 4);           // source 2 = 4 in both
    @(negedge clk);
    check(oddPrio[2*PW +: PW] == 3'd4, "R4", "odd prio src2", 64'(oddPrio[2*PW +: PW]), 4);
    idle(1);
    busOp(1, 60, 2);            // source 15
    busOp(0, 'h4, 0);
    busOp(0, 60, 0);

    curReq = "R6";
    busOp(1, ENB, 32'hFFFF_00A5);
    busOp(0, ENB, 0);
    busOp(1, ENB + ES + 4, 32'h1234);
    busOp(0, ENB + ES + 4, 0);
    busOp(0, ENB + ES, 0);

    curReq = "R7";
    busOp(1, CB, 9);            // wraps to 1; odd variant rejects
    @(negedge clk);
    check(oddThresh == '0, "R7", "odd thresh after 9", 64'(oddThresh), 0);
    idle(1);
    busOp(0, CB, 0);

    curReq = "R5";
    srcLevel[3] = 1'b1; srcLevel[5] = 1'b1;
    idle(1);
    busOp(0, PEND, 0);
    busOp(1, PEND, 32'hFFFF);
    busOp(0, PEND, 0);

    curReq = "R8";
    winId[3:0] = 4'd3;
    busOp(0, CB + 4, 0);
    curReq = "R10";
    idle(3);                    // line 3 stays high, not re-posted
    curReq = "R9";
    busOp(1, CB + 4, 3);
    winId[7:4] = 4'd5;
    busOp(0, CB + CS + 4, 0);
    busOp(1, CB + CS + 4, 20);
    busOp(1, CB + 4, 5);
    curReq = "R8";
    winId[3:0] = 4'd0;
    busOp(0, CB + 4, 0);

    curReq = "R11";
    winId[7:4] = 4'd7;
    srcLevel[7] = 1'b1;
    busOp(0, CB + CS + 4, 0);
    @(negedge clk);
    check(pendingVec[7] == 1'b0 && claimedVec[7] == 1'b1, "R11", "src7 pend/claim",
          64'({pendingVec[7], claimedVec[7]}), 64'(2'b01));
    idle(1);
    curReq = "R10";
    srcLevel[3] = 1'b0; idle(1); srcLevel[3] = 1'b1; idle(2);

    curReq = "R13";
    busOp(0, 0, 0);
    @(negedge clk);
    check(busRdata == 0, "R13", "read addr 0", 64'(busRdata), 0);
    idle(1);
    busOp(0, CB + 8, 0);
    busOp(0, CB + 2 * CS, 0);
    busOp(0, PEND + 4, 0);
    busOp(0, 64, 0);

    curReq = "R1";
    for (int n = 0; n < 600; n++) begin
      int k, c;
      k = int'($urandom_range(0, 6));
      c = int'($urandom_range(0, 2));
      if ($urandom_range(0, 3) == 0) srcLevel[$urandom_range(1, NS - 1)] ^= 1'b1;
      if ($urandom_range(0, 3) == 0) winId = NC*IDW'($urandom);
      busSel = $urandom_range(0, 3) != 0;
      busWr = $urandom_range(0, 1) == 1;
      busWdata = ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 20));
      case (k)
        0: busAddr = 16'(4 * $urandom_range(0, NS));
        1: busAddr = 16'(PEND + 4 * $urandom_range(0, 1));
        2: busAddr = 16'(ENB + c * ES + 4 * $urandom_range(0, 1));
        3, 4: busAddr = 16'(CB + c * CS + 4);
        default: busAddr = 16'(CB + c * CS + 4 * $urandom_range(0, 2));
      endcase
      @(posedge clk); #1;
    end
    busSel = 1'b0;

    curReq = "R12";
    rstN = 1'b0;
    idle(2);
    @(negedge clk);
    check(pendingVec == '0 && claimedVec == '0 && srcPrio == '0 && ctxEnable == '0
          && ctxThresh == '0, "R12", "state after reset", 64'(pendingVec), 0);
    rstN = 1'b1;
    idle(2);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

endmodule